// File: doc/BRIEF.md
# Answer-to-Reset Parser

The parser sits behind a smart-card character receiver and consumes the already de-framed bytes of a card's answer to reset. It learns the coding convention from the leading byte. It follows the chain of interface-byte presence masks, skips the historical bytes, and checks the closing check byte whenever one is owed. When the answer ends, it presents the clock-rate code, the baud-adjust code, the extra guard time, the waiting-time integer and a one-hot set of offered protocols to a later selection stage. Three exclusive status flags report the result: finished, malformed or silent too long.

A `start` pulse arms the parser for a fresh answer, for example when the reset line is raised. A separate one-cycle `etu_tick` marks each elapsed bit time, and the parser uses it to measure the gaps between bytes.

The controller has nine states:

- `ST_IDLE`: after reset; left only by `start`.
- `ST_WAIT_TS`: waits for the leading byte. A valid value goes to `ST_FORMAT`; any other value goes to `ST_FAULT`.
- `ST_FORMAT`: takes the format byte. It moves to `ST_IFACE` if interface bytes are flagged. Otherwise it moves to `ST_HIST` if historical bytes are counted, and otherwise to `ST_DONE`.
- `ST_IFACE`: stays while flagged interface bytes remain. It then goes to `ST_HIST`, or to `ST_CHECK` if a check byte is owed, or to `ST_DONE`.
- `ST_HIST`: goes to `ST_CHECK` or `ST_DONE` after the last historical byte.
- `ST_CHECK`: goes to `ST_DONE` on a zero checksum and to `ST_FAULT` otherwise.
- `ST_DONE`: goes to `ST_FAULT` if a further byte arrives.
- `ST_FAULT`: terminal until the next `start`.
- `ST_TIMEOUT`: reached from any of the four parsing states when the waiting limit expires; terminal until the next `start`.

`start` returns any state to `ST_WAIT_TS`.

Top module: `atr_parser`

## Requirements
- R1: After reset the parser idles and ignores bytes until `start`. `start` (from any state) clears all flags and loads the defaults `fi_code`=1, `di_code`=1, `guard_n`=0, `wi_code`=10, `proto_mask`=0x0001, `conv_inverse`=0. A byte offered in the same cycle as `start` is dropped.
- R2: The leading byte 0x3B selects direct coding (`conv_inverse`=0) and 0x3F selects inverse coding (`conv_inverse`=1). Any other leading value raises `fmt_err`.
- R3: In the format byte, bits 3:0 count the historical bytes (0 to 15). Bits 4, 5, 6 and 7 announce TA1, TB1, TC1 and TD1, which arrive in that order. `done` is not raised before the last counted historical byte.
- R4: In each TD byte, bits 7:4 announce the next group's TA, TB, TC and TD (bit 4 first), and bits 3:0 name a protocol T that sets bit T of `proto_mask`. When no TD byte is received, `proto_mask` is 0x0001.
- R5: TA1 loads `fi_code` from bits 7:4 and `di_code` from bits 3:0. TC1 loads `guard_n`, and TC2 loads `wi_code`. No other interface byte changes any output.
- R6: A check byte is expected only if some TD named a protocol other than 0. When it is expected, the XOR of every byte from the format byte through the check byte must be zero, or `fmt_err` is raised. `done` rises the cycle after the last expected byte.
- R7: When more than MAX_BYTES (32) bytes follow the leading byte, the extra byte raises `fmt_err`.
- R8: A byte received while `done` is high drops `done` and raises `fmt_err`.
- R9: From acceptance of the leading byte until the parse ends, WAIT_ETU `etu_tick` pulses with no byte raise `timeout`. A byte arriving in the same cycle as the final tick wins and restarts the count. No timeout is measured while waiting for the leading byte.
- R10: At most one of `done`, `fmt_err` and `timeout` is high. Each one holds until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arm for a new answer |
| byte_valid | input | 1 | A received byte is present this cycle |
| byte_data | input | 8 | The received byte |
| etu_tick | input | 1 | One pulse per elapsed bit time |
| done | output | 1 | Answer parsed completely |
| fmt_err | output | 1 | Malformed answer |
| timeout | output | 1 | Waiting limit exceeded |
| conv_inverse | output | 1 | Inverse coding convention detected |
| fi_code | output | 4 | Clock-rate conversion code |
| di_code | output | 4 | Baud-rate adjustment code |
| guard_n | output | 8 | Extra guard time in bit times |
| wi_code | output | 8 | Waiting-time integer |
| proto_mask | output | 16 | One-hot set of offered protocols |

## Verification
Two functions can fall in the same cycle: the final `etu_tick` of the waiting window and the arrival of the next byte. The bench provokes this by idling for WAIT_ETU-1 ticks and then presenting the next byte together with a tick; the byte must be parsed, `timeout` must stay low, and the parse must then finish normally. A second collision, `start` together with a leading byte, is judged by checking that the dropped byte leaves the parser still waiting for its leading byte.

// File: rtl/atr_pkg.sv
package atr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_TS,
        ST_FORMAT,
        ST_IFACE,
        ST_HIST,
        ST_CHECK,
        ST_DONE,
        ST_FAULT,
        ST_TIMEOUT
    } atr_state_e;

    typedef enum logic [1:0] {
        SL_TA,
        SL_TB,
        SL_TC,
        SL_TD
    } atr_slot_e;

    localparam int unsigned NPROTO = 16;

    localparam logic [7:0] LEAD_DIRECT  = 8'h3B;
    localparam logic [7:0] LEAD_INVERSE = 8'h3F;

    localparam logic [3:0] DEF_FI = 4'd1;
    localparam logic [3:0] DEF_DI = 4'd1;
    localparam logic [7:0] DEF_N  = 8'd0;
    localparam logic [7:0] DEF_WI = 8'd10;

endpackage

// File: rtl/atr_ck_accum.sv
module atr_ck_accum #(
    parameter int unsigned MAX_BYTES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       cnt_en,
    input  logic       xor_en,
    input  logic [7:0] data,
    output logic [7:0] xor_q,
    output logic       full
);
    localparam int unsigned CW = $clog2(MAX_BYTES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_BYTES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            xor_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
            xor_q <= '0;
        end else begin
            if (cnt_en) cnt_q <= cnt_q + 1'b1;
            if (xor_en) xor_q <= xor_q ^ data;
        end
    end

    assign full = (cnt_q == LIMIT);

endmodule

// File: rtl/atr_wait_timer.sv
module atr_wait_timer #(
    parameter int unsigned WAIT_ETU = 9600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic arm,
    input  logic tick,
    output logic expire
);
    localparam int unsigned TW = $clog2(WAIT_ETU + 1);
    localparam logic [TW-1:0] LAST = TW'(WAIT_ETU - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (clr || !arm)  cnt_q <= '0;
        else if (tick)         cnt_q <= cnt_q + 1'b1;
    end

    assign expire = arm && !clr && tick && (cnt_q == LAST);

endmodule

// File: rtl/atr_field_store.sv
module atr_field_store
    import atr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ta1_we,
    input  logic              tc1_we,
    input  logic              tc2_we,
    input  logic              td_we,
    input  logic [7:0]        data,
    output logic [3:0]        fi,
    output logic [3:0]        di,
    output logic [7:0]        n,
    output logic [7:0]        wi,
    output logic [NPROTO-1:0] proto_mask
);
    logic [NPROTO-1:0] mask_q;
    logic              td_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fi        <= DEF_FI;
            di        <= DEF_DI;
            n         <= DEF_N;
            wi        <= DEF_WI;
            td_seen_q <= 1'b0;
        end else if (clr) begin
            fi        <= DEF_FI;
            di        <= DEF_DI;
            n         <= DEF_N;
            wi        <= DEF_WI;
            td_seen_q <= 1'b0;
        end else begin
            if (ta1_we) begin
                fi <= data[7:4];
                di <= data[3:0];
            end
            if (tc1_we) n  <= data;
            if (tc2_we) wi <= data;
            if (td_we)  td_seen_q <= 1'b1;
        end
    end

    for (genvar j = 0; j < NPROTO; j++) begin : g_proto
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           mask_q[j] <= 1'b0;
            else if (clr)                         mask_q[j] <= 1'b0;
            else if (td_we && data[3:0] == 4'(j)) mask_q[j] <= 1'b1;
        end
    end

    assign proto_mask = td_seen_q ? mask_q : NPROTO'(1);

endmodule

// File: rtl/atr_parser.sv
module atr_parser
    import atr_pkg::*;
#(
    parameter int unsigned WAIT_ETU  = 9600,
    parameter int unsigned MAX_BYTES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    input  logic        etu_tick,
    output logic        done,
    output logic        fmt_err,
    output logic        timeout,
    output logic        conv_inverse,
    output logic [3:0]  fi_code,
    output logic [3:0]  di_code,
    output logic [7:0]  guard_n,
    output logic [7:0]  wi_code,
    output logic [15:0] proto_mask
);
    localparam int unsigned GW = $clog2(MAX_BYTES + 2);

    atr_state_e  state_q, state_d;
    logic [3:0]  pending_q;
    logic [3:0]  hist_q;
    logic [GW-1:0] grp_q;
    logic        need_ck_q;
    logic        conv_q;

    logic        parsing;
    logic        take;
    logic        cnt_full;
    logic        accept;
    logic        expire;
    logic [7:0]  xor_q;
    atr_slot_e   slot;
    logic [3:0]  slot_bit;
    logic [3:0]  pend_after;
    logic        need_after;
    logic        iface_take;
    logic        lead_ok;

    assign parsing = (state_q == ST_FORMAT) || (state_q == ST_IFACE) ||
                     (state_q == ST_HIST)   || (state_q == ST_CHECK);
    assign take    = byte_valid && !start;
    assign accept  = take && parsing && !cnt_full;
    assign lead_ok = (byte_data == LEAD_DIRECT) || (byte_data == LEAD_INVERSE);

    // lowest announced interface byte comes next
    always_comb begin
        if (pending_q[0])      slot = SL_TA;
        else if (pending_q[1]) slot = SL_TB;
        else if (pending_q[2]) slot = SL_TC;
        else                   slot = SL_TD;
    end

    assign slot_bit   = 4'b0001 << slot;
    assign pend_after = (slot == SL_TD) ? byte_data[7:4] : (pending_q & ~slot_bit);
    assign need_after = need_ck_q || ((slot == SL_TD) && (byte_data[3:0] != 4'd0));
    assign iface_take = accept && (state_q == ST_IFACE);

    atr_ck_accum #(.MAX_BYTES(MAX_BYTES)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .cnt_en (accept),
        .xor_en (accept && (state_q != ST_CHECK)),
        .data   (byte_data),
        .xor_q  (xor_q),
        .full   (cnt_full)
    );

    atr_wait_timer #(.WAIT_ETU(WAIT_ETU)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start || (parsing && byte_valid)),
        .arm    (parsing),
        .tick   (etu_tick),
        .expire (expire)
    );

    atr_field_store u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start),
        .ta1_we     (iface_take && slot == SL_TA && grp_q == GW'(1)),
        .tc1_we     (iface_take && slot == SL_TC && grp_q == GW'(1)),
        .tc2_we     (iface_take && slot == SL_TC && grp_q == GW'(2)),
        .td_we      (iface_take && slot == SL_TD),
        .data       (byte_data),
        .fi         (fi_code),
        .di         (di_code),
        .n          (guard_n),
        .wi         (wi_code),
        .proto_mask (proto_mask)
    );

    // next state
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_WAIT_TS;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_WAIT_TS:
                    if (byte_valid) state_d = lead_ok ? ST_FORMAT : ST_FAULT;
                ST_FORMAT:
                    if (byte_valid) begin
                        if (cnt_full)                   state_d = ST_FAULT;
                        else if (byte_data[7:4] != 4'd0) state_d = ST_IFACE;
                        else if (byte_data[3:0] != 4'd0) state_d = ST_HIST;
                        else                            state_d = ST_DONE;
                    end else if (expire) state_d = ST_TIMEOUT;
                ST_IFACE:
                    if (byte_valid) begin
                        if (cnt_full)               state_d = ST_FAULT;
                        else if (pend_after != 4'd0) state_d = ST_IFACE;
                        else if (hist_q != 4'd0)     state_d = ST_HIST;
                        else if (need_after)         state_d = ST_CHECK;
                        else                        state_d = ST_DONE;
                    end else if (expire) state_d = ST_TIMEOUT;
                ST_HIST:
                    if (byte_valid) begin
                        if (cnt_full)              state_d = ST_FAULT;
                        else if (hist_q == 4'd1)   state_d = need_ck_q ? ST_CHECK : ST_DONE;
                    end else if (expire) state_d = ST_TIMEOUT;
                ST_CHECK:
                    if (byte_valid) begin
                        if (cnt_full)                      state_d = ST_FAULT;
                        else if ((xor_q ^ byte_data) == 8'd0) state_d = ST_DONE;
                        else                               state_d = ST_FAULT;
                    end else if (expire) state_d = ST_TIMEOUT;
                ST_DONE:
                    if (byte_valid) state_d = ST_FAULT;
                ST_FAULT: ;
                ST_TIMEOUT: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= '0;
            hist_q    <= '0;
            grp_q     <= '0;
            need_ck_q <= 1'b0;
            conv_q    <= 1'b0;
        end else if (start) begin
            pending_q <= '0;
            hist_q    <= '0;
            grp_q     <= '0;
            need_ck_q <= 1'b0;
            conv_q    <= 1'b0;
        end else if (take && state_q == ST_WAIT_TS) begin
            if (lead_ok) conv_q <= (byte_data == LEAD_INVERSE);
        end else if (accept) begin
            unique case (state_q)
                ST_FORMAT: begin
                    pending_q <= byte_data[7:4];
                    hist_q    <= byte_data[3:0];
                    grp_q     <= GW'(1);
                end
                ST_IFACE: begin
                    pending_q <= pend_after;
                    need_ck_q <= need_after;
                    if (slot == SL_TD) grp_q <= grp_q + 1'b1;
                end
                ST_HIST:  hist_q <= hist_q - 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done         = (state_q == ST_DONE);
        fmt_err      = (state_q == ST_FAULT);
        timeout      = (state_q == ST_TIMEOUT);
        conv_inverse = conv_q;
    end

endmodule

// File: rtl/atr_parser_chk.sv
module atr_parser_chk
    import atr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        byte_valid,
    input logic [7:0]  byte_data,
    input logic        etu_tick,
    input logic        done,
    input logic        fmt_err,
    input logic        timeout,
    input logic [3:0]  fi_code,
    input logic [3:0]  di_code,
    input logic [7:0]  guard_n,
    input logic [7:0]  wi_code,
    input logic [15:0] proto_mask,
    input atr_state_e  state
);

    a_r10_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({done, fmt_err, timeout}) <= 1);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_err && !start) |=> fmt_err);

    a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && !fmt_err && !timeout && proto_mask == 16'h0001 &&
                   fi_code == 4'd1 && di_code == 4'd1 && guard_n == 8'd0 && wi_code == 8'd10));

    a_r2_bad_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_TS && byte_valid && !start &&
         byte_data != 8'h3B && byte_data != 8'h3F) |=> fmt_err);

    a_r8_late_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (done && byte_valid && !start) |=> (fmt_err && !done));

    a_r9_timeout_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> ($past(etu_tick) && !$past(byte_valid) && !$past(start)));

    a_r5_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(fi_code) && $stable(di_code) && $stable(guard_n) &&
                              $stable(wi_code) && $stable(proto_mask)));

    a_r4_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        proto_mask != 16'h0000);

endmodule

bind atr_parser atr_parser_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .etu_tick   (etu_tick),
    .done       (done),
    .fmt_err    (fmt_err),
    .timeout    (timeout),
    .fi_code    (fi_code),
    .di_code    (di_code),
    .guard_n    (guard_n),
    .wi_code    (wi_code),
    .proto_mask (proto_mask),
    .state      (state_q)
);

// File: tb/tb_atr_parser.sv
module tb_atr_parser;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT = 12;
    localparam int LIM  = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        etu_tick = 1'b0;
    logic        done, fmt_err, timeout, conv_inverse;
    logic [3:0]  fi_code, di_code;
    logic [7:0]  guard_n, wi_code;
    logic [15:0] proto_mask;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    atr_parser #(.WAIT_ETU(WAIT), .MAX_BYTES(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid),
        .byte_data(byte_data), .etu_tick(etu_tick), .done(done), .fmt_err(fmt_err),
        .timeout(timeout), .conv_inverse(conv_inverse), .fi_code(fi_code),
        .di_code(di_code), .guard_n(guard_n), .wi_code(wi_code), .proto_mask(proto_mask)
    );

    // ---------------- behavioural reference ----------------
    // m_st: 0 idle, 1 waiting lead, 2 parsing, 3 done, 4 fault, 5 timeout
    int         m_st = 0;
    int         q[$];          // expected items: kind + 8*group
    int         m_hist, m_cnt, m_idle;
    bit         m_need, m_tail, m_td, m_conv;
    logic [7:0] m_x;
    int         m_fi, m_di, m_n, m_wi;
    logic [15:0] m_mask;

    task automatic m_defaults();
        q.delete();
        q.push_back(0);
        m_hist = 0; m_cnt = 0; m_idle = 0;
        m_need = 0; m_tail = 0; m_td = 0; m_conv = 0;
        m_x = 8'h00;
        m_fi = 1; m_di = 1; m_n = 0; m_wi = 10;
        m_mask = 16'h0000;
    endtask

    task automatic m_take(input logic [7:0] d);
        int k, kind, g;
        k = q.pop_front();
        kind = k % 8;
        g = k / 8;
        if (kind == 6) begin
            m_st = ((m_x ^ d) == 8'h00) ? 3 : 4;
            return;
        end
        m_x = m_x ^ d;
        case (kind)
            0: begin
                m_hist = int'(d[3:0]);
                for (int j = 0; j < 4; j++) if (d[4+j]) q.push_back((1 + j) + 8);
            end
            1: if (g == 1) begin m_fi = int'(d[7:4]); m_di = int'(d[3:0]); end
            3: begin
                if (g == 1) m_n = int'(d);
                if (g == 2) m_wi = int'(d);
            end
            4: begin
                m_td = 1;
                m_mask[d[3:0]] = 1'b1;
                if (d[3:0] != 4'd0) m_need = 1;
                for (int j = 0; j < 4; j++) if (d[4+j]) q.push_back((1 + j) + 8 * (g + 1));
            end
            default: ;
        endcase
        if (q.size() == 0) begin
            if (!m_tail) begin
                m_tail = 1;
                repeat (m_hist) q.push_back(5);
                if (m_need) q.push_back(6);
            end
            if (q.size() == 0) m_st = 3;
        end
    endtask

    initial m_defaults();

    always @(posedge clk) begin
        if (!rst_n) begin
            m_defaults(); m_st = 0;
        end else if (start) begin
            m_defaults(); m_st = 1;
        end else begin
            case (m_st)
                1: if (byte_valid) begin
                       if (byte_data == 8'h3B || byte_data == 8'h3F) begin
                           m_conv = (byte_data == 8'h3F); m_st = 2;
                       end else m_st = 4;
                   end
                2: if (byte_valid) begin
                       if (m_cnt == LIM) m_st = 4;
                       else begin m_cnt++; m_idle = 0; m_take(byte_data); end
                   end else if (etu_tick) begin
                       m_idle++;
                       if (m_idle == WAIT) m_st = 5;
                   end
                3: if (byte_valid) m_st = 4;
                default: ;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            chk(done == (m_st == 3), "R10 done", int'(done), int'(m_st == 3));
            chk(fmt_err == (m_st == 4), "R10 fmt_err", int'(fmt_err), int'(m_st == 4));
            chk(timeout == (m_st == 5), "R9 timeout", int'(timeout), int'(m_st == 5));
            chk(conv_inverse == m_conv, "R2 conv", int'(conv_inverse), int'(m_conv));
            chk(int'(fi_code) == m_fi && int'(di_code) == m_di, "R5 fi/di",
                int'({fi_code, di_code}), m_fi * 16 + m_di);
            chk(int'(guard_n) == m_n, "R5 guard", int'(guard_n), m_n);
            chk(int'(wi_code) == m_wi, "R5 wi", int'(wi_code), m_wi);
            chk(proto_mask == (m_td ? m_mask : 16'h0001), "R4 mask",
                int'(proto_mask), int'(m_td ? m_mask : 16'h0001));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send(input logic [7:0] b, input bit tk = 0);
        @(negedge clk);
        byte_valid = 1'b1; byte_data = b; etu_tick = tk;
        @(negedge clk);
        byte_valid = 1'b0; etu_tick = 1'b0;
    endtask

    task automatic go(input bit with_byte = 0, input logic [7:0] b = 8'h00);
        @(negedge clk);
        start = 1'b1; byte_valid = with_byte; byte_data = b;
        @(negedge clk);
        start = 1'b0; byte_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); etu_tick = 1'b1;
            @(negedge clk); etu_tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] ck;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!done && !fmt_err && !timeout && proto_mask == 16'h1 && wi_code == 8'd10,
            "R1 reset", int'({done, fmt_err, timeout}), 0);
        // R1: bytes before start ignored
        send(8'h3B); send(8'h00);
        chk(!done && !fmt_err, "R1 idle ignore", int'({done, fmt_err}), 0);

        // minimal direct answer
        go(); send(8'h3B); send(8'h00);
        chk(done && !conv_inverse && proto_mask == 16'h1, "R2 direct minimal",
            int'({done, conv_inverse}), 2);

        // inverse, TA1/TB1/TD1(T=1), TB2, two historical, check byte
        go(); send(8'h3F);
        ck = 8'h00;
        foreach (seq_a[i]) begin send(seq_a[i]); ck ^= seq_a[i]; end
        chk(!done, "R3 hist pending", int'(done), 0);
        send(8'h22); ck ^= 8'h22;
        chk(!done, "R6 check owed", int'(done), 0);
        send(ck);
        chk(done && fi_code == 4'h9 && di_code == 4'h5 && proto_mask == 16'h0002,
            "R6 check ok", int'({fi_code, di_code}), 'h95);

        // same answer with a wrong check byte
        go(); send(8'h3F);
        foreach (seq_a[i]) send(seq_a[i]);
        send(8'h22); send(ck ^ 8'h01);
        chk(fmt_err && !done, "R6 bad check", int'(fmt_err), 1);

        // bad leading byte
        go(); send(8'h3A);
        chk(fmt_err, "R2 bad lead", int'(fmt_err), 1);

        // TC1, TC2 via two TD groups, T=14 offered
        go(); send(8'h3B);
        ck = 8'h00;
        foreach (seq_b[i]) begin send(seq_b[i]); ck ^= seq_b[i]; end
        send(ck);
        chk(done && guard_n == 8'h05 && wi_code == 8'h20 && proto_mask == 16'h4001,
            "R5 tc fields", int'(wi_code), 'h20);

        // overflow: chained TD bytes
        go(); send(8'h3B); send(8'h80);
        for (int i = 0; i < LIM - 1; i++) send(8'h80);
        chk(!fmt_err && !done, "R7 at limit", int'(fmt_err), 0);
        send(8'h80);
        chk(fmt_err, "R7 overflow", int'(fmt_err), 1);

        // byte after completion
        go(); send(8'h3B); send(8'h00); send(8'h55);
        chk(fmt_err && !done, "R8 late byte", int'({fmt_err, done}), 2);

        // no timeout while waiting for the lead
        go(); ticks(WAIT + 3);
        chk(!timeout, "R9 lead not timed", int'(timeout), 0);
        send(8'h3B); send(8'h10);
        ticks(WAIT);
        chk(timeout, "R9 expiry", int'(timeout), 1);

        // collision: final tick with byte
        go(); send(8'h3B); send(8'h10);
        ticks(WAIT - 1);
        send(8'h11, 1'b1);
        chk(!timeout && done && fi_code == 4'h1, "R9 byte wins", int'(timeout), 0);

        // start together with a lead byte: byte dropped
        go(1'b1, 8'h3B);
        send(8'h3F); send(8'h00);
        chk(done && conv_inverse, "R1 start drops byte", int'({done, conv_inverse}), 3);

        // R10: flags hold
        repeat (5) @(negedge clk);
        chk(done && !fmt_err, "R10 hold", int'(done), 1);

        finish_run();
    end

    logic [7:0] seq_a[6] = '{8'hB2, 8'h95, 8'h00, 8'h21, 8'h45, 8'h11};
    logic [7:0] seq_b[5] = '{8'hC0, 8'h05, 8'hC0, 8'h20, 8'h0E};

endmodule